// File: doc/BRIEF.md
# Floating-Point Register Rename Status File

This block holds the architectural floating-point registers of a dynamically scheduled pipeline. Each register carries a data word, a busy flag and a 4-bit producer tag. When the flag is clear the register holds a usable value. When it is set, the value is still being computed by the reservation station or load buffer that the tag names. The issue stage uses two read ports to collect source operands. A source comes back either as a value with tag 0 or as a nonzero tag that the consuming station must wait for. A rename port records the destination of each issued instruction.

The block also watches the tagged result bus. A waiting register accepts a broadcast only when the broadcast tag equals the tag it currently holds. A later rename of the same register therefore overwrites the producer tag, and the result of the older instruction is dropped at the register. This removes write-after-write hazards without stalling issue. Reservation stations, functional units and memory buffers attach through these ports and are not part of the block.

Top module: `fp_rename_file`

## Requirements
- R1: A synchronous active-high reset clears every busy flag and tag to 0. It loads register i with bits [i*DATA_W +: DATA_W] of the parameter INIT_DATA.
- R2: Each read port returns the stored data of the selected register. When that register is not busy the tag is 0. When it is busy the tag is its nonzero producer tag. Both ports may select the same register.
- R3: Legal producer tags are 1 to 6 (load buffers), 8 and 9 (multiply/divide stations) and 10 to 12 (add stations). Tag 0 means "no producer". A rename with ren_valid=1 sets the selected register busy with ren_tag from the next cycle.
- R4: A rename of a register that is already busy replaces its tag, for example 4 then 10 then 11. A later broadcast of a replaced tag leaves the register busy with the newest tag.
- R5: When a busy register's tag equals res_tag while res_valid=1, the next cycle shows res_data as its data, with busy 0 and tag 0.
- R6: A busy register that sees a broadcast with a different tag keeps its busy flag, tag and data.
- R7: A register that is not busy ignores every broadcast. Its data stays unchanged and it stays not busy.
- R8: If a rename and a matching broadcast reach the same register in the same cycle, the rename wins. The register stays busy with the new tag and keeps its old data.
- R9: When a read port selects a busy register whose tag is being broadcast in that same cycle, the port returns res_data with tag 0.
- R10: A read of a register in the same cycle it is renamed returns its state from before the rename.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ren_valid | input | 1 | Rename request this cycle |
| ren_idx | input | IDX_W (2) | Destination register index |
| ren_tag | input | 4 | Tag of the station that will produce the destination |
| res_valid | input | 1 | Result bus carries a value |
| res_tag | input | 4 | Tag of the broadcasting producer |
| res_data | input | DATA_W (32) | Broadcast value |
| rd0_idx | input | IDX_W (2) | Read port 0 register index |
| rd0_data | output | DATA_W (32) | Read port 0 value |
| rd0_tag | output | 4 | Read port 0 tag, 0 when the value is valid |
| rd1_idx | input | IDX_W (2) | Read port 1 register index |
| rd1_data | output | DATA_W (32) | Read port 1 value |
| rd1_tag | output | 4 | Read port 1 tag, 0 when the value is valid |

## Verification
The assertions assume that every rename and every broadcast carries a legal nonzero tag. They also assume that no two in-flight producers share a tag, because a duplicate would let a stale result retire a register. The random stimulus draws rename tags only from the legal set. Broadcast tags either copy the tag of a register that is currently waiting or come from the legal set. Directed sequences cover the tag chain 4, 10, 11 with a late broadcast of a replaced tag, a rename colliding with its own matching broadcast, and reads that bypass a broadcast or coincide with a rename.

// File: rtl/fprf_pkg.sv
package fprf_pkg;
  localparam int TAG_W = 4;
  localparam logic [TAG_W-1:0] TAG_NONE = '0;

  function automatic logic tag_is_legal(input logic [TAG_W-1:0] t);
    return (t >= 4'd1 && t <= 4'd6) || t == 4'd8 || t == 4'd9 ||
           (t >= 4'd10 && t <= 4'd12);
  endfunction
endpackage

// File: rtl/fprf_entry.sv
module fprf_entry
  import fprf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] INIT = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ren_hit,
  input  logic [TAG_W-1:0]  ren_tag,
  input  logic              res_valid,
  input  logic [TAG_W-1:0]  res_tag,
  input  logic [DATA_W-1:0] res_data,
  output logic              busy_o,
  output logic [TAG_W-1:0]  tag_o,
  output logic [DATA_W-1:0] data_o
);
  logic              busy_q;
  logic [TAG_W-1:0]  tag_q;
  logic [DATA_W-1:0] data_q;
  logic              snoop_match;

  assign snoop_match = busy_q && res_valid && (res_tag == tag_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      tag_q  <= TAG_NONE;
      data_q <= INIT;
    end else if (ren_hit) begin
      busy_q <= 1'b1;
      tag_q  <= ren_tag;
    end else if (snoop_match) begin
      busy_q <= 1'b0;
      tag_q  <= TAG_NONE;
      data_q <= res_data;
    end
  end

  assign busy_o = busy_q;
  assign tag_o  = tag_q;
  assign data_o = data_q;

  AST_RENAME_TAKES: assert property (@(posedge clk) disable iff (rst)
    ren_hit |=> busy_q && tag_q == $past(ren_tag)); // R3
  AST_SNOOP_RETIRES: assert property (@(posedge clk) disable iff (rst)
    (snoop_match && !ren_hit) |=> !busy_q && tag_q == TAG_NONE && data_q == $past(res_data)); // R5
  AST_FOREIGN_TAG_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !snoop_match && !ren_hit) |=> busy_q && $stable(tag_q) && $stable(data_q)); // R6
  AST_IDLE_IGNORES: assert property (@(posedge clk) disable iff (rst)
    (!busy_q && !ren_hit) |=> !busy_q && $stable(data_q)); // R7
  AST_RENAME_WINS: assert property (@(posedge clk) disable iff (rst)
    (snoop_match && ren_hit) |=> busy_q && tag_q == $past(ren_tag) && $stable(data_q)); // R8
endmodule

// File: rtl/fprf_read_port.sv
module fprf_read_port
  import fprf_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int DATA_W   = 32,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic [IDX_W-1:0]                 idx,
  input  logic [NUM_REGS-1:0]              busy_vec,
  input  logic [NUM_REGS-1:0][TAG_W-1:0]   tag_vec,
  input  logic [NUM_REGS-1:0][DATA_W-1:0]  data_vec,
  input  logic                             res_valid,
  input  logic [TAG_W-1:0]                 res_tag,
  input  logic [DATA_W-1:0]                res_data,
  output logic [DATA_W-1:0]                data_o,
  output logic [TAG_W-1:0]                 tag_o
);
  logic sel_busy;
  logic bypass;

  assign sel_busy = busy_vec[idx];
  assign bypass   = sel_busy && res_valid && (res_tag == tag_vec[idx]);

  always_comb begin
    if (bypass) begin
      data_o = res_data;
      tag_o  = TAG_NONE;
    end else begin
      data_o = data_vec[idx];
      tag_o  = sel_busy ? tag_vec[idx] : TAG_NONE;
    end
  end
endmodule

// File: rtl/fp_rename_file.sv
module fp_rename_file
  import fprf_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int DATA_W   = 32,
  parameter logic [NUM_REGS*DATA_W-1:0] INIT_DATA =
    {32'h4080_0000, 32'h4040_0000, 32'h4000_0000, 32'h3F80_0000},
  localparam int IDX_W = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ren_valid,
  input  logic [IDX_W-1:0]  ren_idx,
  input  logic [TAG_W-1:0]  ren_tag,
  input  logic              res_valid,
  input  logic [TAG_W-1:0]  res_tag,
  input  logic [DATA_W-1:0] res_data,
  input  logic [IDX_W-1:0]  rd0_idx,
  output logic [DATA_W-1:0] rd0_data,
  output logic [TAG_W-1:0]  rd0_tag,
  input  logic [IDX_W-1:0]  rd1_idx,
  output logic [DATA_W-1:0] rd1_data,
  output logic [TAG_W-1:0]  rd1_tag
);
  logic [NUM_REGS-1:0]             busy_vec;
  logic [NUM_REGS-1:0][TAG_W-1:0]  tag_vec;
  logic [NUM_REGS-1:0][DATA_W-1:0] data_vec;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    fprf_entry #(
      .DATA_W (DATA_W),
      .INIT   (INIT_DATA[g*DATA_W +: DATA_W])
    ) i_entry (
      .clk       (clk),
      .rst       (rst),
      .ren_hit   (ren_valid && (ren_idx == IDX_W'(g))),
      .ren_tag   (ren_tag),
      .res_valid (res_valid),
      .res_tag   (res_tag),
      .res_data  (res_data),
      .busy_o    (busy_vec[g]),
      .tag_o     (tag_vec[g]),
      .data_o    (data_vec[g])
    );
  end

  fprf_read_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) i_rd0 (
    .idx (rd0_idx), .busy_vec (busy_vec), .tag_vec (tag_vec), .data_vec (data_vec),
    .res_valid (res_valid), .res_tag (res_tag), .res_data (res_data),
    .data_o (rd0_data), .tag_o (rd0_tag)
  );

  fprf_read_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) i_rd1 (
    .idx (rd1_idx), .busy_vec (busy_vec), .tag_vec (tag_vec), .data_vec (data_vec),
    .res_valid (res_valid), .res_tag (res_tag), .res_data (res_data),
    .data_o (rd1_data), .tag_o (rd1_tag)
  );

  AST_LEGAL_REN_TAG: assert property (@(posedge clk) disable iff (rst)
    ren_valid |-> tag_is_legal(ren_tag)); // R3
  AST_LEGAL_RES_TAG: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> tag_is_legal(res_tag)); // R3
  AST_RD0_BUSY_TAG: assert property (@(posedge clk) disable iff (rst)
    (busy_vec[rd0_idx] && !(res_valid && res_tag == tag_vec[rd0_idx])) |-> rd0_tag != TAG_NONE); // R2
endmodule

// File: tb/test_fp_rename_file.sv
`timescale 1ns/1ps
module test_fp_rename_file;
  localparam int NR = 4;
  localparam int DW = 32;
  localparam logic [NR*DW-1:0] INIT = {32'hDDDD_0003, 32'hCCCC_0002, 32'hBBBB_0001, 32'hAAAA_0000};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ren_valid = 0, res_valid = 0;
  logic [1:0] ren_idx = 0, rd0_idx = 0, rd1_idx = 0;
  logic [3:0] ren_tag = 0, res_tag = 0;
  logic [DW-1:0] res_data = 0;
  logic [DW-1:0] rd0_data, rd1_data;
  logic [3:0] rd0_tag, rd1_tag;

  always #4 clk = ~clk;

  fp_rename_file #(.NUM_REGS(NR), .DATA_W(DW), .INIT_DATA(INIT)) i_fp_rename_file (
    .clk(clk), .rst(rst), .ren_valid(ren_valid), .ren_idx(ren_idx), .ren_tag(ren_tag),
    .res_valid(res_valid), .res_tag(res_tag), .res_data(res_data),
    .rd0_idx(rd0_idx), .rd0_data(rd0_data), .rd0_tag(rd0_tag),
    .rd1_idx(rd1_idx), .rd1_data(rd1_data), .rd1_tag(rd1_tag));

  logic          m_busy [NR];
  logic [3:0]    m_tag  [NR];
  logic [DW-1:0] m_data [NR];
  int checks = 0, fails = 0;
  bit done = 0;

  function automatic logic [3:0] legal_tag(input int k);
    case (k % 11)
      0: return 4'd1;  1: return 4'd2;  2: return 4'd3;  3: return 4'd4;
      4: return 4'd5;  5: return 4'd6;  6: return 4'd8;  7: return 4'd9;
      8: return 4'd10; 9: return 4'd11; default: return 4'd12;
    endcase
  endfunction

  function automatic logic [3:0] exp_tag(input int i);
    if (m_busy[i] && res_valid && res_tag == m_tag[i]) return 4'd0;
    return m_busy[i] ? m_tag[i] : 4'd0;
  endfunction

  function automatic logic [DW-1:0] exp_data(input int i);
    if (m_busy[i] && res_valid && res_tag == m_tag[i]) return res_data;
    return m_data[i];
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act_d, input logic [3:0] act_t,
                       input logic [DW-1:0] exp_d, input logic [3:0] exp_t);
    checks++;
    if (act_d !== exp_d || act_t !== exp_t) begin
      fails++;
      $display("FAIL %s: actual data=%h tag=%0d expected data=%h tag=%0d",
               req, act_d, act_t, exp_d, exp_t);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NR; i++) begin
      m_busy[i] = 0; m_tag[i] = 0; m_data[i] = INIT[i*DW +: DW];
    end
  endtask

  // Drive one cycle at the falling edge, check both reads before the rising edge, then update model.
  task automatic step(input string req, input logic rv, input logic [1:0] ri, input logic [3:0] rt,
                      input logic bv, input logic [3:0] bt, input logic [DW-1:0] bd,
                      input logic [1:0] a, input logic [1:0] b);
    @(negedge clk);
    ren_valid = rv; ren_idx = ri; ren_tag = rt;
    res_valid = bv; res_tag = bt; res_data = bd;
    rd0_idx = a; rd1_idx = b;
    #1;
    check(req, rd0_data, rd0_tag, exp_data(a), exp_tag(a));
    check(req, rd1_data, rd1_tag, exp_data(b), exp_tag(b));
    @(posedge clk);
    for (int i = 0; i < NR; i++) begin
      if (rv && ri == 2'(i)) begin
        m_busy[i] = 1; m_tag[i] = rt;
      end else if (m_busy[i] && bv && bt == m_tag[i]) begin
        m_busy[i] = 0; m_tag[i] = 0; m_data[i] = bd;
      end
    end
  endtask

  task automatic idle_read(input string req, input logic [1:0] a, input logic [1:0] b);
    step(req, 0, 0, 0, 0, 0, 0, a, b);
  endtask

  initial begin
    int n;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R1: reset values through both ports
    idle_read("R1", 0, 1);
    idle_read("R1", 2, 3);
    // R3/R4: tag chain 4 -> 10 -> 11 on register 0; R10 read during rename sees old state
    step("R10", 1, 0, 4'd4, 0, 0, 0, 0, 0);
    step("R4", 1, 0, 4'd10, 0, 0, 0, 0, 1);
    step("R4", 1, 0, 4'd11, 0, 0, 0, 0, 0);
    idle_read("R3", 0, 0);
    // R4: stale tag 4 broadcast is dropped
    step("R4", 0, 0, 0, 1, 4'd4, 32'h1111_1111, 1, 2);
    idle_read("R4", 0, 0);
    // R6: other busy register ignores foreign tag; R9 bypass on broadcast of tag 11
    step("R6", 1, 2, 4'd8, 0, 0, 0, 2, 0);
    step("R9", 0, 0, 0, 1, 4'd11, 32'h2222_2222, 0, 2);
    idle_read("R5", 0, 2);
    // R7: idle register ignores broadcast carrying any tag
    step("R7", 0, 0, 0, 1, 4'd3, 32'h3333_3333, 1, 3);
    idle_read("R7", 1, 3);
    // R8: rename collides with matching broadcast on register 2
    step("R8", 1, 2, 4'd9, 1, 4'd8, 32'h4444_4444, 2, 2);
    idle_read("R8", 2, 2);
    step("R5", 0, 0, 0, 1, 4'd9, 32'h5555_5555, 3, 2);
    idle_read("R5", 2, 0);
    // Random mix
    void'($urandom(32'd20251));
    n = 3000;
    for (int k = 0; k < n; k++) begin
      logic rv, bv;
      logic [1:0] ri, a, b;
      logic [3:0] rt, bt;
      int pick;
      rv = ($urandom % 3) == 0;
      ri = 2'($urandom);
      rt = legal_tag($urandom);
      bv = ($urandom % 2) == 0;
      pick = $urandom % NR;
      bt = (m_busy[pick] && ($urandom % 4 != 0)) ? m_tag[pick] : legal_tag($urandom);
      a = 2'($urandom); b = 2'($urandom);
      step("R2", rv, ri, rt, bv, bt, $urandom, a, b);
    end
    // R1: reset again mid-run
    @(negedge clk); rst = 1; ren_valid = 0; res_valid = 0;
    @(posedge clk); model_reset();
    @(negedge clk); rst = 0;
    idle_read("R1", 3, 2);
    idle_read("R1", 1, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule